// File: doc/BRIEF.md
# System Control Register Page

This block decodes accesses into one 4 KB page of system control registers. The page holds:

- a vector table base register whose low seven bits always read back as zero;
- a reset control register protected by a 16-bit key;
- a small bank of byte-wide priority values for system handlers;
- a read-only identification window;
- a write-only software trigger that raises one external interrupt by its number;
- a read-only word that reports how many external interrupt lines are configured.

The host presents one access per cycle on a plain strobe. The strobe carries the direction, a 12-bit page offset, a size code and write data. The block never stalls, so there is no back-pressure. Every accepted access gets a response exactly one cycle later, carrying read data and an error flag.

Register state drives the outputs continuously: the vector base and the flat vector of priority bytes. Pulse outputs are registered, last one cycle, and appear in the same cycle as the response to the write that caused them. These are the system reset request and the software trigger strobe with its interrupt number.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, rsp_vld, rsp_err, sysrst_req and swtrig_vld are 0, vec_base is 0 and every priority byte is 0.
- R2: Each cycle with acc_vld high produces rsp_vld high in the next cycle, with rsp_rdata and rsp_err for that access; with no access, rsp_vld is 0 and rsp_rdata is 0.
- R3: A word write (acc_size 2) to offset 0xD08 stores the write data with bits 6:0 cleared; a word read of 0xD08 returns the stored value, which also drives vec_base.
- R4: A word write to offset 0xD0C acts only when data bits 31:16 equal 0x05FA. Such a keyed write with data bit 2 set pulses sysrst_req for one cycle. Any other write to 0xD0C does nothing. A word read of 0xD0C returns 0x0FA05000.
- R5: Offsets 0xD18 to 0xD23 hold one priority byte each, with byte k of prio_bytes (bits 8k+7:8k) at offset 0xD18+k. They accept byte, halfword and word accesses (acc_size 0, 1, 2) at any start offset, with lane i of the data word (bits 8i+7:8i) mapped to offset start+i. Lanes past 0xD23 are dropped on write and read 0. acc_size 3 touches no byte.
- R6: Offsets 0xFE0 to 0xFFF are read-only for any size. An offset with bits 1:0 zero reads byte ((offset-0xFE0)>>2) of parameter ID_VALS, zero-extended, with byte j taken from bits 8j+7:8j. Other offsets read 0. Writes change nothing and raise no error.
- R7: A word write to 0xF00 takes data bits 8:0 as an interrupt number. When that number is below NUM_IRQ, swtrig_vld pulses for one cycle with swtrig_irq equal to the number; otherwise nothing happens.
- R8: A word read of offset 0x004 returns NUM_IRQ/32 - 1. Writes to it change nothing.
- R9: At offsets 0x004, 0xD08, 0xD0C and 0xF00, an access whose size is not word reads 0, is ignored on write, and raises no error.
- R10: Any offset outside the mapped registers and ranges reads 0, ignores writes, and sets rsp_err for its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the page |
| acc_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = reserved |
| acc_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| rsp_vld | output | 1 | Response valid, one cycle after the access |
| rsp_rdata | output | 32 | Read data for the access |
| rsp_err | output | 1 | Access hit an unmapped offset |
| vec_base | output | 32 | Vector table base, bits 6:0 zero |
| prio_bytes | output | NPRIO*8 | Priority bytes, byte k for offset 0xD18+k |
| sysrst_req | output | 1 | One-cycle system reset request |
| swtrig_vld | output | 1 | One-cycle software trigger strobe |
| swtrig_irq | output | 9 | Interrupt number of the trigger |

## Verification
The priority window is swept at every start offset and every size. A design that misplaces the little-endian lanes, wraps past the last byte, or writes lanes beyond the access size diverges from the byte model.

All 512 trigger numbers are applied, which catches an off-by-one at the interrupt limit and any use of data bits above bit 8. The reset register is hit with the right key, a wrong key, the key without the request bit, and a halfword size, so a missing key compare or size check shows as a stray reset pulse.

Misaligned and unmapped offsets, and writes into the identification window, expose decoders that alias neighbours, flag errors on read-only space, or let a write modify state.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [11:0] OFF_IRQ_LINES = 12'h004;
  localparam logic [11:0] OFF_VEC_BASE  = 12'hD08;
  localparam logic [11:0] OFF_RST_CTRL  = 12'hD0C;
  localparam logic [11:0] OFF_PRIO_LO   = 12'hD18;
  localparam logic [11:0] OFF_SW_TRIG   = 12'hF00;
  localparam logic [11:0] OFF_ID_LO     = 12'hFE0;

  localparam logic [15:0] RST_KEY      = 16'h05FA;
  localparam logic [31:0] RST_CTRL_RD  = 32'h0FA05000;
  localparam logic [31:0] VEC_MASK     = 32'hFFFFFF80;
  localparam int          RST_REQ_BIT  = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_LINES,
    RG_VEC,
    RG_RST,
    RG_TRIG,
    RG_PRIO,
    RG_ID,
    RG_BADSZ
  } region_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NPRIO = 12
) (
  input  logic [11:0] addr,
  input  logic [1:0]  size,
  output region_e     region
);
  localparam logic [11:0] PRIO_HI = OFF_PRIO_LO + 12'(NPRIO - 1);

  logic word_acc;
  assign word_acc = (size == SZ_WORD);

  always_comb begin
    region = RG_NONE;
    if (addr >= OFF_PRIO_LO && addr <= PRIO_HI) begin
      region = RG_PRIO;
    end else if (addr >= OFF_ID_LO) begin
      region = RG_ID;
    end else begin
      case (addr)
        OFF_IRQ_LINES: region = word_acc ? RG_LINES : RG_BADSZ;
        OFF_VEC_BASE:  region = word_acc ? RG_VEC   : RG_BADSZ;
        OFF_RST_CTRL:  region = word_acc ? RG_RST   : RG_BADSZ;
        OFF_SW_TRIG:   region = word_acc ? RG_TRIG  : RG_BADSZ;
        default:       region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_prio_bank.sv
module sysctl_prio_bank #(
  parameter int NPRIO = 12,
  localparam int SW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     start,
  input  logic [2:0]        nbytes,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NPRIO*8-1:0] bytes_o
);
  logic [7:0]       mem   [NPRIO];
  logic [NPRIO-1:0] we;
  logic [7:0]       wbyte [NPRIO];

  always_comb begin
    we = '0;
    for (int j = 0; j < NPRIO; j++) begin
      wbyte[j] = 8'h00;
      for (int l = 0; l < 4; l++) begin
        if (l < int'(nbytes) && j == int'(start) + l) begin
          we[j]    = wr_en;
          wbyte[j] = wdata[l*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int l = 0; l < 4; l++) begin
      for (int j = 0; j < NPRIO; j++) begin
        if (l < int'(nbytes) && j == int'(start) + l) rdata[l*8 +: 8] = mem[j];
      end
    end
  end

  for (genvar g = 0; g < NPRIO; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)     mem[g] <= 8'h00;
      else if (we[g]) mem[g] <= wbyte[g];
    end
    assign bytes_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/sysctl_id_rom.sv
module sysctl_id_rom #(
  parameter logic [63:0] ID_VALS = 64'h8877665544332211
) (
  input  logic [4:0]  addr,
  output logic [31:0] rdata
);
  always_comb begin
    if (addr[1:0] != 2'b00) rdata = '0;
    else                    rdata = {24'h0, ID_VALS[addr[4:2]*8 +: 8]};
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          NUM_IRQ = 64,
  parameter int          NPRIO   = 12,
  parameter logic [63:0] ID_VALS = 64'h8877665544332211,
  localparam int         IRQW    = 9,
  localparam int         PSW     = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_vld,
  input  logic                acc_wr,
  input  logic [11:0]         acc_addr,
  input  logic [1:0]          acc_size,
  input  logic [31:0]         acc_wdata,
  output logic                rsp_vld,
  output logic [31:0]         rsp_rdata,
  output logic                rsp_err,
  output logic [31:0]         vec_base,
  output logic [NPRIO*8-1:0]  prio_bytes,
  output logic                sysrst_req,
  output logic                swtrig_vld,
  output logic [IRQW-1:0]     swtrig_irq
);
  localparam logic [31:0] LINES_RD = 32'(NUM_IRQ / 32 - 1);
  localparam logic [9:0]  IRQ_LIM  = 10'(NUM_IRQ);

  region_e     region;
  logic        wr_hit;
  logic [31:0] prio_rd, id_rd, rd_mux;
  logic [11:0] prio_off;
  logic        trig_ok, rst_ok;

  sysctl_decode #(.NPRIO(NPRIO)) u_dec (
    .addr   (acc_addr),
    .size   (acc_size),
    .region (region)
  );

  assign wr_hit   = acc_vld && acc_wr;
  assign prio_off = acc_addr - OFF_PRIO_LO;

  sysctl_prio_bank #(.NPRIO(NPRIO)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hit && region == RG_PRIO),
    .start   (prio_off[PSW-1:0]),
    .nbytes  (size_bytes(acc_size)),
    .wdata   (acc_wdata),
    .rdata   (prio_rd),
    .bytes_o (prio_bytes)
  );

  sysctl_id_rom #(.ID_VALS(ID_VALS)) u_id (
    .addr  (acc_addr[4:0]),
    .rdata (id_rd)
  );

  assign trig_ok = ({1'b0, acc_wdata[IRQW-1:0]} < IRQ_LIM);
  assign rst_ok  = (acc_wdata[31:16] == RST_KEY) && acc_wdata[RST_REQ_BIT];

  always_comb begin
    case (region)
      RG_LINES: rd_mux = LINES_RD;
      RG_VEC:   rd_mux = vec_base;
      RG_RST:   rd_mux = RST_CTRL_RD;
      RG_PRIO:  rd_mux = prio_rd;
      RG_ID:    rd_mux = id_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      vec_base   <= '0;
      sysrst_req <= 1'b0;
      swtrig_vld <= 1'b0;
      swtrig_irq <= '0;
    end else begin
      rsp_vld    <= acc_vld;
      rsp_rdata  <= (acc_vld && !acc_wr) ? rd_mux : '0;
      rsp_err    <= acc_vld && (region == RG_NONE);
      sysrst_req <= wr_hit && (region == RG_RST) && rst_ok;
      swtrig_vld <= wr_hit && (region == RG_TRIG) && trig_ok;
      if (wr_hit && region == RG_TRIG && trig_ok) swtrig_irq <= acc_wdata[IRQW-1:0];
      if (wr_hit && region == RG_VEC) vec_base <= acc_wdata & VEC_MASK;
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_vld,
  input logic        acc_wr,
  input logic [11:0] acc_addr,
  input logic [1:0]  acc_size,
  input logic [31:0] acc_wdata,
  input logic        rsp_vld,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic [31:0] vec_base,
  input logic        sysrst_req,
  input logic        swtrig_vld,
  input logic [8:0]  swtrig_irq
);
  logic vec_wr;
  assign vec_wr = acc_vld && acc_wr && acc_addr == 12'hD08 && acc_size == 2'd2;

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> rsp_vld);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !rsp_vld);

  // R3
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base[6:0] == 7'h00);

  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_wr |=> $stable(vec_base));

  // R4
  rst_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && acc_addr == 12'hD0C && acc_size == 2'd2
     && acc_wdata[31:16] == 16'h05FA && acc_wdata[2]) |=> sysrst_req);

  // R4
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && acc_wr && acc_addr == 12'hD0C) |=> !sysrst_req);

  // R7
  trig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swtrig_vld |-> (int'(swtrig_irq) < NUM_IRQ));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'h0 && rsp_vld));
endmodule

bind sysctl_regs sysctl_regs_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_vld    (acc_vld),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .acc_size   (acc_size),
  .acc_wdata  (acc_wdata),
  .rsp_vld    (rsp_vld),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .vec_base   (vec_base),
  .sysrst_req (sysrst_req),
  .swtrig_vld (swtrig_vld),
  .swtrig_irq (swtrig_irq)
);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          NUM_IRQ    = 64;
  localparam int          NPRIO      = 12;
  localparam logic [63:0] ID_VALS    = 64'hC3B2A19084736251;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic        acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_vld, rsp_err, sysrst_req, swtrig_vld;
  logic [31:0] rsp_rdata, vec_base;
  logic [NPRIO*8-1:0] prio_bytes;
  logic [8:0]  swtrig_irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] pm [NPRIO];
  logic [31:0] vmodel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs #(.NUM_IRQ(NUM_IRQ), .NPRIO(NPRIO), .ID_VALS(ID_VALS)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .vec_base(vec_base), .prio_bytes(prio_bytes), .sysrst_req(sysrst_req),
    .swtrig_vld(swtrig_vld), .swtrig_irq(swtrig_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; returns at the negedge after the response edge
  task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] d);
    acc_vld = 1'b1; acc_wr = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
  endtask

  task automatic chk_prio(input string tag);
    logic [NPRIO*8-1:0] e;
    for (int k = 0; k < NPRIO; k++) e[k*8 +: 8] = pm[k];
    n_vec++;
    if (prio_bytes !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, prio_bytes, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPRIO; k++) pm[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_vld", {31'h0, rsp_vld}, 32'h0);
    chk("R1 rsp_err", {31'h0, rsp_err}, 32'h0);
    chk("R1 sysrst_req", {31'h0, sysrst_req}, 32'h0);
    chk("R1 swtrig_vld", {31'h0, swtrig_vld}, 32'h0);
    chk("R1 vec_base", vec_base, 32'h0);
    chk_prio("R1 prio");

    // R2 response timing and idle
    acc(1'b0, 12'hD08, 2'd2, 32'h0);
    chk("R2 rsp_vld after access", {31'h0, rsp_vld}, 32'h1);
    @(negedge clk);
    chk("R2 rsp_vld idle", {31'h0, rsp_vld}, 32'h0);
    chk("R2 rdata idle", rsp_rdata, 32'h0);

    // R3 vector base
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = 32'h9E3779B9 * (i + 1) ^ 32'h0000007F;
      acc(1'b1, 12'hD08, 2'd2, d);
      vmodel = d & 32'hFFFFFF80;
      chk("R3 vec_base port", vec_base, vmodel);
      acc(1'b0, 12'hD08, 2'd2, 32'h0);
      chk("R3 vec read", rsp_rdata, vmodel);
      chk("R2 rsp_vld", {31'h0, rsp_vld}, 32'h1);
    end

    // R9 non-word access to word registers
    acc(1'b1, 12'hD08, 2'd1, 32'hFFFFFFFF);
    chk("R9 halfword write ignored", vec_base, vmodel);
    chk("R9 no err", {31'h0, rsp_err}, 32'h0);
    acc(1'b0, 12'hD08, 2'd0, 32'h0);
    chk("R9 byte read zero", rsp_rdata, 32'h0);
    acc(1'b0, 12'hD0C, 2'd1, 32'h0);
    chk("R9 halfword rst read zero", rsp_rdata, 32'h0);
    acc(1'b1, 12'hD0C, 2'd1, 32'h05FA0004);
    chk("R9 halfword keyed no reset", {31'h0, sysrst_req}, 32'h0);
    acc(1'b1, 12'hF00, 2'd0, 32'h00000003);
    chk("R9 byte trigger ignored", {31'h0, swtrig_vld}, 32'h0);

    // R4 reset control
    acc(1'b1, 12'hD0C, 2'd2, 32'h05FA0004);
    chk("R4 keyed reset pulse", {31'h0, sysrst_req}, 32'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'h0, sysrst_req}, 32'h0);
    acc(1'b1, 12'hD0C, 2'd2, 32'h05FB0004);
    chk("R4 wrong key", {31'h0, sysrst_req}, 32'h0);
    acc(1'b1, 12'hD0C, 2'd2, 32'h05FA0003);
    chk("R4 key without bit2", {31'h0, sysrst_req}, 32'h0);
    acc(1'b0, 12'hD0C, 2'd2, 32'h0);
    chk("R4 read fixed", rsp_rdata, 32'h0FA05000);

    // R8 interrupt line count
    acc(1'b0, 12'h004, 2'd2, 32'h0);
    chk("R8 line count", rsp_rdata, 32'(NUM_IRQ / 32 - 1));
    acc(1'b1, 12'h004, 2'd2, 32'hFFFFFFFF);
    acc(1'b0, 12'h004, 2'd2, 32'h0);
    chk("R8 write ignored", rsp_rdata, 32'(NUM_IRQ / 32 - 1));

    // R5 priority sweep: every start offset and size
    for (int o = 0; o < NPRIO; o++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] d, e;
        int nb;
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        d = 32'h61C88647 * (o * 4 + sz + 1);
        acc(1'b1, 12'hD18 + 12'(o), 2'(sz), d);
        for (int l = 0; l < nb; l++) if (o + l < NPRIO) pm[o + l] = d[l*8 +: 8];
        chk_prio("R5 prio after write");
        acc(1'b0, 12'hD18 + 12'(o), 2'(sz), 32'h0);
        e = '0;
        for (int l = 0; l < nb; l++) if (o + l < NPRIO) e[l*8 +: 8] = pm[o + l];
        chk("R5 prio read", rsp_rdata, e);
        chk("R5 no err", {31'h0, rsp_err}, 32'h0);
      end
    end

    // R6 identification window
    for (int o = 0; o < 32; o++) begin
      logic [31:0] e;
      e = (o % 4 == 0) ? {24'h0, ID_VALS[(o / 4) * 8 +: 8]} : 32'h0;
      acc(1'b0, 12'hFE0 + 12'(o), 2'd2, 32'h0);
      chk("R6 id read", rsp_rdata, e);
      chk("R6 id no err", {31'h0, rsp_err}, 32'h0);
    end
    acc(1'b1, 12'hFE4, 2'd2, 32'hFFFFFFFF);
    chk("R6 id write no err", {31'h0, rsp_err}, 32'h0);
    acc(1'b0, 12'hFE4, 2'd0, 32'h0);
    chk("R6 id unchanged byte read", rsp_rdata, {24'h0, ID_VALS[15:8]});

    // R7 software trigger, all numbers
    for (int n = 0; n < 512; n++) begin
      acc(1'b1, 12'hF00, 2'd2, 32'(n));
      chk("R7 trigger valid", {31'h0, swtrig_vld}, (n < NUM_IRQ) ? 32'h1 : 32'h0);
      if (n < NUM_IRQ) chk("R7 trigger irq", {23'h0, swtrig_irq}, 32'(n));
    end
    acc(1'b1, 12'hF00, 2'd2, 32'hFFFFFE05);
    chk("R7 upper bits ignored", {22'h0, swtrig_vld, swtrig_irq}, 32'h205);

    // R10 unmapped offsets
    begin
      logic [11:0] bad [7] = '{12'h000, 12'h010, 12'hD00, 12'hD24, 12'hD09, 12'hFDC, 12'h100};
      for (int i = 0; i < 7; i++) begin
        acc(1'b0, bad[i], 2'd2, 32'h0);
        chk("R10 err flag", {31'h0, rsp_err}, 32'h1);
        chk("R10 read zero", rsp_rdata, 32'h0);
      end
    end
    acc(1'b1, 12'hD09, 2'd2, 32'hFFFFFFFF);
    chk("R10 write err", {31'h0, rsp_err}, 32'h1);
    chk("R10 vec unchanged", vec_base, vmodel);
    chk_prio("R10 prio unchanged");
    @(negedge clk);
    chk("R10 err one cycle", {31'h0, rsp_err}, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule